// File: doc/BRIEF.md
# Host-Link UART with Handshake Pacing

This block is the byte transport between a controller and its host over a serial line. It sends and receives 8-bit characters (one start bit, eight data bits LSB first, one stop bit, no parity). The transmit side takes bytes from a valid/ready stream. The receive side oversamples the incoming line and stores each character in a FIFO, which the host-side logic drains through a second valid/ready stream.

Both directions are paced one byte at a time. A high level on the incoming clear-to-send line holds back the next character, but it never cuts short a character already on the line. The outgoing request-to-send line is raised from the receive FIFO fill level, using a programmable threshold and hysteresis.

The line rate is set by a divisor. A rate change is requested at any time. It is held pending, and takes effect only once the last byte of the response that acknowledges it has left the line at the old rate.

Top module: `hostlink_uart`

## Requirements
- R1: After reset, txd is high, rts is low, rx_valid is low, and tx_ready is high while cts is low. The active divisor is RST_DIV = CLK_HZ/(16*RST_BAUD), which gives 115.2 kbps at the default clock.
- R2: Each transmitted character is a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts 16*div clock cycles. txd drops in the cycle after the clock edge that accepts the byte.
- R3: A byte is accepted on a clock edge where tx_valid and tx_ready are both high. tx_ready is high only while the transmitter is idle and the synchronised cts is low. It rises in the cycle after a stop bit ends.
- R4: cts passes through a two-stage synchroniser, so tx_ready falls two cycles after cts rises. A cts rise during a character does not shorten it: the character finishes through its stop bit, and no further character starts until cts is seen low again.
- R5: A pulse on baud_req captures baud_div as a pending divisor. The pending divisor is applied when the stop bit of the next byte accepted with tx_last=1 ends. That byte, and every byte before it, is sent at the old rate.
- R6: A divisor of 0 acts as 1, which gives the fastest rate of 16 clock cycles per bit.
- R7: The receiver samples at 16 ticks per bit. It confirms the start bit at mid-bit and samples each data bit and the stop bit at mid-bit. Received bytes leave the FIFO in arrival order on rx_data, and one byte is removed on each edge where rx_valid and rx_ready are both high.
- R8: A stop bit sampled low stores its byte with rx_ferr=1. A stop bit sampled high gives rx_ferr=0.
- R9: A low pulse on rxd that is shorter than half a bit is discarded and stores nothing.
- R10: rts is set one cycle after the FIFO level exceeds rts_thresh. It is cleared one cycle after level + rts_hyst <= rts_thresh, and holds its value in between.
- R11: A byte that arrives while the FIFO holds FIFO_DEPTH entries is dropped, and the stored bytes are unchanged.
- R12: The receiver uses the same active divisor as the transmitter, including a divisor that has just been switched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_last | input | 1 | Byte ends a response (releases a pending rate) |
| tx_ready | output | 1 | Transmitter accepts a byte |
| txd | output | 1 | Serial output line |
| cts | input | 1 | High: peer asks transmitter to pause |
| rxd | input | 1 | Serial input line |
| rts | output | 1 | High: ask peer to stop sending |
| rx_data | output | 8 | Head byte of the receive FIFO |
| rx_ferr | output | 1 | Framing error flag of the head byte |
| rx_valid | output | 1 | FIFO not empty |
| rx_ready | input | 1 | Remove the head byte |
| rts_thresh | input | $clog2(FIFO_DEPTH+1) | Fill level above which rts rises |
| rts_hyst | input | $clog2(FIFO_DEPTH+1) | Hysteresis for rts release |
| baud_div | input | DIV_W | Requested divisor (clock cycles per 1/16 bit) |
| baud_req | input | 1 | Capture baud_div as pending divisor |

## Verification
The transmit line and tx_ready are predicted for every cycle. At each falling clock edge the bench compares txd with the expected bit, which starts one cycle after the accepting edge and lasts 16*div cycles per bit. It compares tx_ready with a prediction that goes idle one cycle after the stop bit and follows cts with two cycles of delay. Receive results arrive near the middle of the stop bit plus two synchroniser cycles, so the bench reads the FIFO only after the whole frame and one idle bit. rts is checked three cycles after each change in fill level, which allows for its one-cycle register.

// File: rtl/hlu_pkg.sv
package hlu_pkg;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_STOP
   } tx_state_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   typedef struct packed {
      logic       ferr;
      logic [7:0] data;
   } rx_word_t;

endpackage

// File: rtl/hlu_sync.sv
module hlu_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hlu_tx.sv
module hlu_tx
   import hlu_pkg::*;
#(
   parameter int DIV_W   = 12,
   parameter int RST_DIV = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cts_s,
   input  logic [7:0]       tx_data,
   input  logic             tx_valid,
   input  logic             tx_last,
   output logic             tx_ready,
   output logic             txd,
   input  logic             baud_req,
   input  logic [DIV_W-1:0] baud_div,
   output logic [DIV_W-1:0] div_act
);

   localparam int CW = DIV_W + 4;

   tx_state_e        state_q;
   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    bit_len;
   logic [7:0]       sh_q;
   logic [2:0]       bitn_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] pend_q;
   logic [DIV_W-1:0] next_q;
   logic             pend_v_q;
   logic             apply_q;
   logic             txd_q;

   assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
   assign bit_len  = {div_eff, 4'b0000};
   assign tx_ready = (state_q == TX_IDLE) && !cts_s;
   assign txd      = txd_q;
   assign div_act  = div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TX_IDLE;
         cnt_q    <= '0;
         sh_q     <= '0;
         bitn_q   <= '0;
         div_q    <= DIV_W'(RST_DIV);
         pend_q   <= '0;
         next_q   <= '0;
         pend_v_q <= 1'b0;
         apply_q  <= 1'b0;
         txd_q    <= 1'b1;
      end else begin
         case (state_q)
            TX_IDLE: begin
               txd_q <= 1'b1;
               if (tx_valid && tx_ready) begin
                  sh_q    <= tx_data;
                  txd_q   <= 1'b0;
                  cnt_q   <= bit_len - CW'(1);
                  state_q <= TX_START;
                  if (tx_last && pend_v_q) begin
                     apply_q  <= 1'b1;
                     next_q   <= pend_q;
                     pend_v_q <= 1'b0;
                  end
               end
            end
            TX_START: begin
               if (cnt_q == '0) begin
                  txd_q   <= sh_q[0];
                  sh_q    <= {1'b0, sh_q[7:1]};
                  bitn_q  <= '0;
                  cnt_q   <= bit_len - CW'(1);
                  state_q <= TX_DATA;
               end else begin
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            TX_DATA: begin
               if (cnt_q == '0) begin
                  cnt_q <= bit_len - CW'(1);
                  if (bitn_q == 3'd7) begin
                     txd_q   <= 1'b1;
                     state_q <= TX_STOP;
                  end else begin
                     txd_q  <= sh_q[0];
                     sh_q   <= {1'b0, sh_q[7:1]};
                     bitn_q <= bitn_q + 3'd1;
                  end
               end else begin
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            TX_STOP: begin
               if (cnt_q == '0) begin
                  state_q <= TX_IDLE;
                  if (apply_q) begin
                     div_q   <= next_q;
                     apply_q <= 1'b0;
                  end
               end else begin
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            default: state_q <= TX_IDLE;
         endcase
         if (baud_req) begin
            pend_q   <= baud_div;
            pend_v_q <= 1'b1;
         end
      end
   end

   // R2: the line rests high between characters
   a_r2_idle_line_high : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_IDLE) |-> txd_q);

   // R3: a synchronised pause request keeps the transmitter idle
   a_r3_cts_blocks_start : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_IDLE && cts_s) |=> (state_q == TX_IDLE));

   // R4: a started character runs to its stop bit
   a_r4_char_completes : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_START || state_q == TX_DATA) |=> (state_q != TX_IDLE));

   // R5: the divisor only moves at the end of a stop bit
   a_r5_div_moves_at_stop : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != TX_STOP) |=> $stable(div_q));

endmodule

// File: rtl/hlu_rx.sv
module hlu_rx
   import hlu_pkg::*;
#(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd_s,
   input  logic [DIV_W-1:0] div,
   output logic             push,
   output rx_word_t         word
);

   rx_state_e        state_q;
   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] div_eff;
   logic [3:0]       tcnt_q;
   logic [2:0]       bitn_q;
   logic [7:0]       sh_q;
   logic             push_q;
   rx_word_t         word_q;
   logic             tick;

   assign div_eff = (div == '0) ? DIV_W'(1) : div;
   assign tick    = (pre_q == div_eff - DIV_W'(1));
   assign push    = push_q;
   assign word    = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         pre_q   <= '0;
         tcnt_q  <= '0;
         bitn_q  <= '0;
         sh_q    <= '0;
         push_q  <= 1'b0;
         word_q  <= '0;
      end else begin
         push_q <= 1'b0;
         if (state_q == RX_IDLE) pre_q <= '0;
         else                    pre_q <= tick ? '0 : pre_q + DIV_W'(1);
         case (state_q)
            RX_IDLE: begin
               tcnt_q <= '0;
               if (!rxd_s) state_q <= RX_START;
            end
            RX_START: begin
               if (tick) begin
                  if (tcnt_q == 4'd7) begin
                     tcnt_q  <= '0;
                     bitn_q  <= '0;
                     state_q <= rxd_s ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt_q <= tcnt_q + 4'd1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  tcnt_q <= tcnt_q + 4'd1;
                  if (tcnt_q == 4'd15) begin
                     sh_q <= {rxd_s, sh_q[7:1]};
                     if (bitn_q == 3'd7) state_q <= RX_STOP;
                     else                bitn_q  <= bitn_q + 3'd1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  tcnt_q <= tcnt_q + 4'd1;
                  if (tcnt_q == 4'd15) begin
                     push_q      <= 1'b1;
                     word_q.ferr <= !rxd_s;
                     word_q.data <= sh_q;
                     state_q     <= rxd_s ? RX_IDLE : RX_HOLD;
                  end
               end
            end
            RX_HOLD: begin
               if (rxd_s) state_q <= RX_IDLE;
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R7: a byte is only delivered out of the stop-bit phase
   a_r7_push_after_stop : assert property (@(posedge clk) disable iff (!rst_n)
      push_q |-> ($past(state_q) == RX_STOP));

   // R9: a start bit found high at mid-bit is abandoned
   a_r9_glitch_dropped : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_START && tick && tcnt_q == 4'd7 && rxd_s) |=> (state_q == RX_IDLE && !push_q));

endmodule

// File: rtl/hlu_rxq.sv
module hlu_rxq
   import hlu_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  rx_word_t      din,
   input  logic          pop_req,
   input  logic [LW-1:0] thresh,
   input  logic [LW-1:0] hyst,
   output rx_word_t      dout,
   output logic          valid,
   output logic          rts
);

   localparam int AW = $clog2(DEPTH);

   rx_word_t      mem [DEPTH];
   logic [AW-1:0] wp_q;
   logic [AW-1:0] rp_q;
   logic [LW-1:0] cnt_q;
   logic [LW:0]   rel_sum;
   logic          full;
   logic          do_push;
   logic          do_pop;
   logic          rts_q;

   assign full    = (cnt_q == LW'(DEPTH));
   assign valid   = (cnt_q != '0);
   assign do_pop  = pop_req && valid;
   assign do_push = push && !full;
   assign dout    = mem[rp_q];
   assign rel_sum = {1'b0, cnt_q} + {1'b0, hyst};
   assign rts     = rts_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         rts_q <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
         if (cnt_q > thresh)                 rts_q <= 1'b1;
         else if (rel_sum <= {1'b0, thresh}) rts_q <= 1'b0;
      end
   end

   // R11: a full FIFO keeps its level when nothing is removed
   a_r11_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop_req) |=> (cnt_q == LW'(DEPTH)));

   // R10: fill level above the threshold raises rts next cycle
   a_r10_rts_raise : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > thresh) |=> rts_q);

   // R10: fill level at or under the release mark drops rts next cycle
   a_r10_rts_release : assert property (@(posedge clk) disable iff (!rst_n)
      (rel_sum <= {1'b0, thresh}) |=> !rts_q);

endmodule

// File: rtl/hostlink_uart.sv
module hostlink_uart
   import hlu_pkg::*;
#(
   parameter int CLK_HZ      = 48_000_000,
   parameter int RST_BAUD    = 115_200,
   parameter int RST_DIV     = CLK_HZ / (16 * RST_BAUD),
   parameter int DIV_W       = 12,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [7:0]                       tx_data,
   input  logic                             tx_valid,
   input  logic                             tx_last,
   output logic                             tx_ready,
   output logic                             txd,
   input  logic                             cts,
   input  logic                             rxd,
   output logic                             rts,
   output logic [7:0]                       rx_data,
   output logic                             rx_ferr,
   output logic                             rx_valid,
   input  logic                             rx_ready,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]  rts_thresh,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]  rts_hyst,
   input  logic [DIV_W-1:0]                 baud_div,
   input  logic                             baud_req
);

   localparam int LW = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_divw
      $error("DIV_W must be at least 2");
   end
   if (RST_DIV < 1 || RST_DIV >= (1 << DIV_W)) begin : g_bad_rstdiv
      $error("RST_DIV must fit in DIV_W bits and be nonzero");
   end

   logic             cts_s;
   logic             rxd_s;
   logic [DIV_W-1:0] div_act;
   logic             rx_push;
   rx_word_t         rx_word;
   rx_word_t         head;

   hlu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts),
      .q     (cts_s)
   );

   hlu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rxd_s)
   );

   hlu_tx #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cts_s    (cts_s),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_last  (tx_last),
      .tx_ready (tx_ready),
      .txd      (txd),
      .baud_req (baud_req),
      .baud_div (baud_div),
      .div_act  (div_act)
   );

   hlu_rx #(.DIV_W(DIV_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .rxd_s (rxd_s),
      .div   (div_act),
      .push  (rx_push),
      .word  (rx_word)
   );

   hlu_rxq #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (rx_push),
      .din     (rx_word),
      .pop_req (rx_ready),
      .thresh  (rts_thresh),
      .hyst    (rts_hyst),
      .dout    (head),
      .valid   (rx_valid),
      .rts     (rts)
   );

   assign rx_data = head.data;
   assign rx_ferr = head.ferr;

endmodule

// File: tb/hostlink_uart_test.sv
module hostlink_uart_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_last = 1'b0;
   logic       tx_ready;
   logic       txd;
   logic       cts = 1'b0;
   logic       rxd = 1'b1;
   logic       rts;
   logic [7:0] rx_data;
   logic       rx_ferr;
   logic       rx_valid;
   logic       rx_ready = 1'b0;
   logic [4:0] rts_thresh = 5'd3;
   logic [4:0] rts_hyst = 5'd1;
   logic [11:0] baud_div = 12'd0;
   logic       baud_req = 1'b0;

   always #2 clk = ~clk;

   hostlink_uart #(.CLK_HZ(3_686_400)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_data    (tx_data),
      .tx_valid   (tx_valid),
      .tx_last    (tx_last),
      .tx_ready   (tx_ready),
      .txd        (txd),
      .cts        (cts),
      .rxd        (rxd),
      .rts        (rts),
      .rx_data    (rx_data),
      .rx_ferr    (rx_ferr),
      .rx_valid   (rx_valid),
      .rx_ready   (rx_ready),
      .rts_thresh (rts_thresh),
      .rts_hyst   (rts_hyst),
      .baud_div   (baud_div),
      .baud_req   (baud_req)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase = "R1";

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // behavioural reference: expected line bits per cycle, rate, pause view
   bit         exp_q[$];
   int         p_bits = 32;
   bit         pv = 1'b0;
   int         pd = 0;
   bit         m1 = 1'b0;
   bit         m2 = 1'b0;
   bit         model_on = 1'b0;
   logic [8:0] rxm_q[$];
   bit         rts_m = 1'b0;

   function automatic int plen(int d);
      return 16 * ((d == 0) ? 1 : d);
   endfunction

   always @(posedge clk) begin
      m1 <= cts;
      m2 <= m1;
   end

   always @(negedge clk) begin
      bit e;
      bit r;
      if (model_on) begin
         r = (exp_q.size() == 0) && !m2;
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
         chk({phase, " txd"}, {31'b0, txd}, {31'b0, e});
         chk({phase, " tx_ready"}, {31'b0, tx_ready}, {31'b0, r});
         if (tx_valid && tx_ready) begin
            for (int k = 0; k < p_bits; k++) exp_q.push_back(1'b0);
            for (int b = 0; b < 8; b++)
               for (int k = 0; k < p_bits; k++) exp_q.push_back(tx_data[b]);
            for (int k = 0; k < p_bits; k++) exp_q.push_back(1'b1);
            if (tx_last && pv) begin
               p_bits = plen(pd);
               pv = 1'b0;
            end
         end
         if (baud_req) begin
            pv = 1'b1;
            pd = int'(baud_div);
         end
      end
   end

   task automatic send(logic [7:0] d, logic l);
      @(posedge clk); #1;
      tx_data = d; tx_last = l; tx_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (tx_ready) break;
      end
      @(posedge clk); #1;
      tx_valid = 1'b0; tx_last = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic set_baud(logic [11:0] d);
      @(posedge clk); #1;
      baud_div = d; baud_req = 1'b1;
      @(posedge clk); #1;
      baud_req = 1'b0;
   endtask

   function automatic void rts_update();
      int lvl = rxm_q.size();
      if (lvl > 3) rts_m = 1'b1;
      else if (lvl + 1 <= 3) rts_m = 1'b0;
   endfunction

   task automatic rx_frame(logic [7:0] d, bit bad);
      int p = p_bits;
      @(posedge clk); #1 rxd = 1'b0;
      for (int b = 0; b < 8; b++) begin
         repeat (p) @(posedge clk);
         #1 rxd = d[b];
      end
      repeat (p) @(posedge clk);
      #1 rxd = !bad;
      repeat (p) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (p) @(posedge clk);
      if (rxm_q.size() < 16) rxm_q.push_back({bad, d});
      rts_update();
   endtask

   task automatic rx_pop(string req);
      logic [8:0] e;
      @(negedge clk);
      chk({req, " rx_valid"}, {31'b0, rx_valid}, 32'd1);
      if (rxm_q.size() > 0) begin
         e = rxm_q.pop_front();
         chk({req, " rx word"}, {23'b0, rx_ferr, rx_data}, {23'b0, e});
      end
      @(posedge clk); #1 rx_ready = 1'b1;
      @(posedge clk); #1 rx_ready = 1'b0;
      rts_update();
   endtask

   task automatic rts_check(string req);
      repeat (3) @(negedge clk);
      chk({req, " rts"}, {31'b0, rts}, {31'b0, rts_m});
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 txd", {31'b0, txd}, 32'd1);
      chk("R1 rts", {31'b0, rts}, 32'd0);
      chk("R1 rx_valid", {31'b0, rx_valid}, 32'd0);
      chk("R1 tx_ready", {31'b0, tx_ready}, 32'd1);
      model_on = 1'b1;

      // R1 default rate and R2/R3 framing, back to back
      phase = "R2";
      send(8'hA5, 1'b0);
      send(8'h3C, 1'b0);
      drain();

      // R4: pause raised mid-character
      phase = "R4";
      send(8'h5A, 1'b0);
      repeat (96) @(posedge clk);
      #1 cts = 1'b1;
      fork
         send(8'hC9, 1'b0);
         begin
            repeat (800) @(posedge clk);
            #1 cts = 1'b0;
         end
      join
      drain();

      // R5: deferred rate change
      phase = "R5";
      set_baud(12'd3);
      send(8'h11, 1'b0);
      send(8'h22, 1'b1);
      send(8'h33, 1'b0);
      drain();

      // R6: zero divisor acts as one
      phase = "R6";
      set_baud(12'd0);
      send(8'h44, 1'b1);
      send(8'h55, 1'b0);
      drain();

      // R7 / R12: reception at the switched rate
      phase = "R7";
      rx_frame(8'h81, 1'b0);
      rx_frame(8'h7E, 1'b0);
      rx_pop("R7");
      rx_pop("R12");

      // R8: low stop bit
      rx_frame(8'hC3, 1'b1);
      rx_pop("R8");

      // R9: short low pulse
      @(posedge clk); #1 rxd = 1'b0;
      repeat (3) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (400) @(posedge clk);
      @(negedge clk);
      chk("R9 glitch stores nothing", {31'b0, rx_valid}, 32'd0);
      rx_frame(8'h99, 1'b0);
      rx_pop("R9");

      // R10: threshold 3, hysteresis 1
      for (int i = 0; i < 4; i++) begin
         rx_frame(8'hE0 + 8'(i), 1'b0);
         rts_check("R10 fill");
      end
      rx_pop("R10");
      rts_check("R10 hold");
      rx_pop("R10");
      rts_check("R10 release");

      // R11: overflow drops newest bytes
      for (int i = 0; i < 18; i++) rx_frame(8'h40 + 8'(i), 1'b0);
      rts_check("R11 full");
      for (int i = 0; i < 16; i++) rx_pop("R11");
      @(negedge clk);
      chk("R11 empty after drain", {31'b0, rx_valid}, 32'd0);
      rts_check("R10 empty");

      summary();
      $finish;
   end

endmodule